// File: doc/BRIEF.md
# Reset-Cause and Watchdog-Arm Control Register

This block is the small system-control corner of a microcontroller. It records why the chip last came out of reset, and it holds the one-way latch that arms the watchdog timer. It also carries the sleep-request and CPU-stop control bits. A second, single-bit configuration register picks how much RAM the boot code clears, and that register keeps its contents through a watchdog reset.

Software reaches the block through a byte-wide register port. Reads are combinational from the address. Writes land on the rising clock edge while the write strobe is high.

There are two kinds of reset:
- **Cold reset** is power-on or external reset. It is asynchronous and returns everything to its initial state, including the configuration register.
- **Watchdog reset** is a synchronous one-cycle event. It records its own cause, drops the sleep and stop controls, and leaves the watchdog arming and the configuration register untouched.

Once software clears the power-on flag, the watchdog is armed. Only a cold reset can disarm it.

Top module: `sys_reset_ctl`

## Requirements
- R1: While `porIn` or `extRstIn` is high, all state is cleared at once. The status register then reads 0x10 with bit 7 equal to `gieIn`, and the configuration register reads 0x00. `wdtEnable`, `sleepReq`, `cpuStop` and `ramInitMin` are all 0.
- R2: Status bit 4 is the power-on flag, and `wdtEnable` is its inverse.
  - A status write with bit 4 = 0 clears the flag, so `wdtEnable` rises after that edge.
  - Writing 1 to bit 4 never sets the flag again.
  - Once high, `wdtEnable` stays high until a cold reset, including through watchdog events.
- R3: Status bit 5 is the watchdog-cause flag.
  - A watchdog event sets it.
  - A status write with bit 5 = 0 clears it.
  - A write with bit 5 = 1 leaves it unchanged, so software can never set it.
- R4: Status bit 7 always reads the current `gieIn` level. Writes to bit 7 have no effect.
- R5: Status bit 3 is the sleep request and drives `sleepReq`. A status write loads it. A `wakePulse` clears it on the next edge, and the wake wins over a write of 1 in the same cycle.
- R6: Status bit 0 is the stop control and drives `cpuStop`. Writing 1 sets it. Writing 0 does not clear it, so only a cold reset or a watchdog event releases it.
- R7: The configuration register (address 1) holds `ramInitMin` in bit 0. A value of 0 means the maximal RAM initialisation. Bits 7 to 1 read 0. A watchdog event leaves bit 0 unchanged.
- R8: On a cycle with `wdtRstEvt` high:
  - the watchdog-cause flag is set;
  - the sleep and stop bits are cleared;
  - any bus write in that same cycle is discarded.
- R9: Status bits 6, 2 and 1 always read 0, whatever is written to them.
- R10: The status register is at address 0 and the configuration register at address 1. `busRdData` follows `busAddr` and the register state in the same cycle. Register writes become visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| extRstIn | input | 1 | External reset, active high, asynchronous |
| wdtRstEvt | input | 1 | Watchdog-reset event, one clock cycle, synchronous |
| wakePulse | input | 1 | Wake-up pulse that clears the sleep request |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | DATA_W | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdData | output | DATA_W | Combinational read data |
| gieIn | input | 1 | Global interrupt enable level, mirrored in status bit 7 |
| wdtEnable | output | 1 | Watchdog armed |
| sleepReq | output | 1 | Low-power sleep request |
| cpuStop | output | 1 | Halt the processor |
| ramInitMin | output | 1 | 1 selects the minimal RAM initialisation |

## Verification
Read data is due in the same cycle as the address and the `gieIn` level that produce it. The bench therefore compares `busRdData` a moment after it drives the inputs, before the clock edge. Every write, watchdog event and wake pulse shows up on the control outputs exactly one edge later. The bench advances its reference model at that edge and compares all four outputs at the following falling edge. A cold reset acts without a clock, so its effect is checked one time step after the reset pin rises.

// File: rtl/sys_reset_ctl_pkg.sv
package sys_reset_ctl_pkg;
  localparam int BIT_GIE   = 7;
  localparam int BIT_WDRS  = 5;
  localparam int BIT_PORS  = 4;
  localparam int BIT_SLEEP = 3;
  localparam int BIT_STOP  = 0;
  localparam int BIT_RAMIN = 0;

  typedef struct packed {
    logic wrStatus;
    logic wrCfg;
    logic wdtHit;
    logic wake;
  } ctlStrobes_t;
endpackage

// File: rtl/sys_reset_ctl_ctrl.sv
module sys_reset_ctl_ctrl
  import sys_reset_ctl_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              wdtRstEvt,
  input  logic              wakePulse,
  output ctlStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] StatusSel = STATUS_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CfgSel    = CFG_ADDR[ADDR_W-1:0];

  logic writeOk;

  always_comb begin
    // A watchdog event swallows any bus write in the same cycle.
    writeOk          = busWrEn && !wdtRstEvt;
    strobes.wrStatus = writeOk && (busAddr == StatusSel);
    strobes.wrCfg    = writeOk && (busAddr == CfgSel);
    strobes.wdtHit   = wdtRstEvt;
    strobes.wake     = wakePulse;
  end
endmodule

// File: rtl/sys_reset_ctl_dp.sv
module sys_reset_ctl_dp
  import sys_reset_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input  logic              clk,
  input  logic              coldRst,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              gieIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              porsFlag,
  output logic              sleepBit,
  output logic              stopBit,
  output logic              ramMinBit
);
  localparam logic [ADDR_W-1:0] StatusSel = STATUS_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CfgSel    = CFG_ADDR[ADDR_W-1:0];

  logic wdrsFlag;

  // Reset-cause flags and the sleep/stop controls.
  always_ff @(posedge clk or posedge coldRst) begin
    if (coldRst) begin
      porsFlag <= 1'b1;
      wdrsFlag <= 1'b0;
      sleepBit <= 1'b0;
      stopBit  <= 1'b0;
    end else if (strobes.wdtHit) begin
      wdrsFlag <= 1'b1;
      sleepBit <= 1'b0;
      stopBit  <= 1'b0;
    end else begin
      if (strobes.wrStatus) begin
        porsFlag <= porsFlag & busWrData[BIT_PORS];
        wdrsFlag <= wdrsFlag & busWrData[BIT_WDRS];
        stopBit  <= stopBit | busWrData[BIT_STOP];
      end
      // A wake pulse overrides a write of 1 to the sleep bit.
      if (strobes.wake) begin
        sleepBit <= 1'b0;
      end else if (strobes.wrStatus) begin
        sleepBit <= busWrData[BIT_SLEEP];
      end
    end
  end

  // Configuration register: only a cold reset clears it.
  always_ff @(posedge clk or posedge coldRst) begin
    if (coldRst) begin
      ramMinBit <= 1'b0;
    end else if (strobes.wrCfg) begin
      ramMinBit <= busWrData[BIT_RAMIN];
    end
  end

  // Combinational read mux.
  always_comb begin
    busRdData = '0;
    if (busAddr == StatusSel) begin
      busRdData[BIT_GIE]   = gieIn;
      busRdData[BIT_WDRS]  = wdrsFlag;
      busRdData[BIT_PORS]  = porsFlag;
      busRdData[BIT_SLEEP] = sleepBit;
      busRdData[BIT_STOP]  = stopBit;
    end else if (busAddr == CfgSel) begin
      busRdData[BIT_RAMIN] = ramMinBit;
    end
  end
endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl
  import sys_reset_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              extRstIn,
  input  logic              wdtRstEvt,
  input  logic              wakePulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              gieIn,
  output logic              wdtEnable,
  output logic              sleepReq,
  output logic              cpuStop,
  output logic              ramInitMin
);
  ctlStrobes_t strobes;
  logic        coldRst;
  logic        porsFlag;

  assign coldRst = porIn | extRstIn;

  sys_reset_ctl_ctrl #(
    .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .CFG_ADDR(CFG_ADDR)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .wdtRstEvt(wdtRstEvt),
    .wakePulse(wakePulse),
    .strobes(strobes)
  );

  sys_reset_ctl_dp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .CFG_ADDR(CFG_ADDR)
  ) u_dp (
    .clk(clk),
    .coldRst(coldRst),
    .strobes(strobes),
    .busWrData(busWrData),
    .busAddr(busAddr),
    .gieIn(gieIn),
    .busRdData(busRdData),
    .porsFlag(porsFlag),
    .sleepBit(sleepReq),
    .stopBit(cpuStop),
    .ramMinBit(ramInitMin)
  );

  assign wdtEnable = ~porsFlag;
endmodule

// File: rtl/sys_reset_ctl_chk.sv
module sys_reset_ctl_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input logic              clk,
  input logic              porIn,
  input logic              extRstIn,
  input logic              wdtRstEvt,
  input logic              wakePulse,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              gieIn,
  input logic              wdtEnable,
  input logic              sleepReq,
  input logic              cpuStop,
  input logic              ramInitMin
);
  localparam logic [ADDR_W-1:0] StatusSel = STATUS_ADDR[ADDR_W-1:0];

  logic coldRst;
  assign coldRst = porIn | extRstIn;

  // R2: once armed, the watchdog stays armed until a cold reset.
  assert_wdt_sticky_R2: assert property (@(posedge clk) disable iff (coldRst)
    wdtEnable |=> wdtEnable);

  // R2: arming needs a status write with bit 4 = 0 and no watchdog event.
  assert_wdt_arm_only_by_write_R2: assert property (@(posedge clk) disable iff (coldRst)
    (!wdtEnable && !(busWrEn && !wdtRstEvt && busAddr == StatusSel && !busWrData[4]))
    |=> !wdtEnable);

  // R4: bit 7 mirrors the interrupt-enable level.
  assert_gie_mirror_R4: assert property (@(posedge clk) disable iff (coldRst)
    (busAddr == StatusSel) |-> (busRdData[7] == gieIn));

  // R5: a wake pulse clears the sleep request.
  assert_wake_clears_R5: assert property (@(posedge clk) disable iff (coldRst)
    wakePulse |=> !sleepReq);

  // R6: stop holds unless a watchdog event releases it.
  assert_stop_holds_R6: assert property (@(posedge clk) disable iff (coldRst)
    (cpuStop && !wdtRstEvt) |=> cpuStop);

  // R7: the configuration bit survives a watchdog event.
  assert_cfg_kept_R7: assert property (@(posedge clk) disable iff (coldRst)
    wdtRstEvt |=> $stable(ramInitMin));

  // R8: a watchdog event drops sleep and stop.
  assert_wdt_clears_R8: assert property (@(posedge clk) disable iff (coldRst)
    wdtRstEvt |=> (!sleepReq && !cpuStop));

  // R9: reserved status bits read zero.
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (coldRst)
    (busAddr == StatusSel) |-> (busRdData[6] == 1'b0 && busRdData[2:1] == 2'b00));
endmodule

bind sys_reset_ctl sys_reset_ctl_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .STATUS_ADDR(STATUS_ADDR),
  .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk),
  .porIn(porIn),
  .extRstIn(extRstIn),
  .wdtRstEvt(wdtRstEvt),
  .wakePulse(wakePulse),
  .busAddr(busAddr),
  .busWrData(busWrData),
  .busWrEn(busWrEn),
  .busRdData(busRdData),
  .gieIn(gieIn),
  .wdtEnable(wdtEnable),
  .sleepReq(sleepReq),
  .cpuStop(cpuStop),
  .ramInitMin(ramInitMin)
);

// File: tb/sys_reset_ctl_tb.sv
module sys_reset_ctl_tb;
  logic       clk = 1'b0;
  logic       porIn = 1'b1;
  logic       extRstIn = 1'b0;
  logic       wdtRstEvt = 1'b0;
  logic       wakePulse = 1'b0;
  logic [0:0] busAddr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busRdData;
  logic       gieIn = 1'b0;
  logic       wdtEnable, sleepReq, cpuStop, ramInitMin;

  int errors = 0;
  int checks = 0;

  // Reference model state.
  bit mPors = 1'b1, mWdrs = 1'b0, mSleep = 1'b0, mStop = 1'b0, mRam = 1'b0;

  always #10 clk = ~clk;

  sys_reset_ctl u_dut (
    .clk(clk), .porIn(porIn), .extRstIn(extRstIn), .wdtRstEvt(wdtRstEvt),
    .wakePulse(wakePulse), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .gieIn(gieIn),
    .wdtEnable(wdtEnable), .sleepReq(sleepReq), .cpuStop(cpuStop),
    .ramInitMin(ramInitMin)
  );

  function automatic logic [7:0] modelRead(input logic a, input logic g);
    if (a == 1'b0) return {g, 1'b0, mWdrs, mPors, mSleep, 2'b00, mStop};
    return {7'd0, mRam};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check(tag, "outputs{wdtEn,sleep,stop,ramMin}",
          {4'd0, wdtEnable, sleepReq, cpuStop, ramInitMin},
          {4'd0, ~mPors, mSleep, mStop, mRam});
  endtask

  // One bus cycle, started at a falling edge.
  task automatic cyc(input logic a, input logic [7:0] d, input logic we,
                     input logic wdt, input logic wake, input logic g,
                     input string tag);
    busAddr = a; busWrData = d; busWrEn = we;
    wdtRstEvt = wdt; wakePulse = wake; gieIn = g;
    #1;
    check(tag, "read", busRdData, modelRead(a, g));
    @(posedge clk);
    if (wdt) begin
      mWdrs = 1'b1; mSleep = 1'b0; mStop = 1'b0;
    end else begin
      if (we && a == 1'b0) begin
        mWdrs = mWdrs & d[5];
        mPors = mPors & d[4];
        mStop = mStop | d[0];
        mSleep = d[3];
      end
      if (we && a == 1'b1) mRam = d[0];
      if (wake) mSleep = 1'b0;
    end
    @(negedge clk);
    busWrEn = 1'b0; wdtRstEvt = 1'b0; wakePulse = 1'b0;
    checkOutputs(tag);
  endtask

  task automatic coldReset(input bit useExt);
    if (useExt) extRstIn = 1'b1; else porIn = 1'b1;
    #1;
    mPors = 1'b1; mWdrs = 1'b0; mSleep = 1'b0; mStop = 1'b0; mRam = 1'b0;
    busAddr = 1'b0; gieIn = 1'b1;
    #1;
    check("R1", "status after cold reset", busRdData, 8'h90);
    busAddr = 1'b1;
    #1;
    check("R1", "cfg after cold reset", busRdData, 8'h00);
    checkOutputs("R1");
    @(negedge clk);
    porIn = 1'b0; extRstIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    coldReset(1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    // R2/R3/R4: writing ones sets neither flag; sleep and stop set.
    cyc(1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    // R9: reserved bits stay 0 after writing ones.
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R6: writing 0 leaves stop; R2: clearing bit 4 arms the watchdog.
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
    cyc(1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R8: watchdog event sets cause, drops stop and sleep, arming kept.
    cyc(1'b0, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    cyc(1'b0, 8'h09, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    // R7: configuration register and its survival through a watchdog event.
    cyc(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    cyc(1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    // R5: wake wins over a concurrent write of 1.
    cyc(1'b0, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    cyc(1'b0, 8'h08, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    cyc(1'b0, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // R1: external reset disarms the watchdog and clears configuration.
    coldReset(1'b1);
    cyc(1'b0, 8'h46, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R10: mixed traffic compared against the model every cycle.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[15:8], r[1], (r[4:2] == 3'd0), (r[7:5] == 3'd0), r[16], "R10");
    end
    coldReset(1'b0);
    finishRun();
  end
endmodule